// File: doc/BRIEF.md
# Conversion-Start Serial Sample Reader

This block is a synchronous master for a 12-bit sampling converter that talks over three wires: a conversion-start line that the master drives, a serial clock that the master generates, and a serial data line that the converter drives. The converter begins a conversion when the start line rises. It stays asleep while the line is held high. When the line falls, the converter samples its input and turns on its data output. The converter changes each data bit on a falling serial-clock edge, and the master captures the bit on the next rising edge.

When a request arrives, the reader latches a conversion wait and a clock-divider setting and keeps the start line high for the wait. It then lowers the line and produces twelve serial-clock pulses, collecting the bits most-significant first. It then raises the start line again, which begins the next conversion or puts the converter to sleep. At the same time it presents the assembled word with a one-cycle valid pulse. Between requests the start line stays high, so the converter rests in its low-power state.

The controller is a five-state machine. WAKE holds the start line low for one cycle after reset. IDLE holds the line high and waits; the transition IDLE→CONV is taken on a request. CONV counts the wait down with the line high; CONV→SHIFT is taken when the count reaches zero. SHIFT holds the line low and runs the serial clock; SHIFT→DONE is taken on the falling edge that ends the twelfth high phase. DONE raises valid for one cycle and always moves to IDLE. WAKE always moves to IDLE.

Top module: `sar_rd_top`

## Requirements
- R1: While reset is asserted, conv_o, sclk_o, busy_o and valid_o are 0 and data_o is 0. In the first cycle after reset is released conv_o is still 0. From the following cycle on, conv_o is 1.
- R2: A start_i of 1 sampled in IDLE makes busy_o 1 in the next cycle, with conv_o still 1. Exactly wait_i+1 cycles after busy_o rises, conv_o falls. busy_o never rises unless start_i was 1 at the previous edge.
- R3: sclk_o is 0 whenever busy_o is 0. During readout the half-period is H system cycles, where H = div_i, or H = 1 when div_i is 0. The first rise of sclk_o comes H cycles after conv_o falls.
- R4: sdi_i is captured at each rising edge of sclk_o. The first captured bit becomes data_o[11], and each later bit goes to the next lower position down to data_o[0].
- R5: Exactly 12 rising sclk_o edges occur per request. sclk_o is 1 only while conv_o is 0. Anything the converter drives after the twelfth bit is never captured.
- R6: valid_o is 1 for exactly one cycle, 24·H cycles after conv_o falls. In that cycle busy_o falls and data_o takes the new word. data_o does not change in any cycle where valid_o is 0.
- R7: start_i is ignored in CONV, SHIFT and DONE. A request made during these states neither starts a second transfer nor changes the timing of the current one.
- R8: wait_i and div_i are latched when a request is accepted. Changing them later has no effect on the running transfer.
- R9: conv_o is 1 in DONE and IDLE, so the converter converts and then sleeps between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request for one sample |
| div_i | input | DIV_W | Serial clock half-period in system cycles (0 means 1) |
| wait_i | input | WAIT_W | Conversion wait in system cycles, minus one |
| sdi_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | DATA_W | Last assembled sample word |
| valid_o | output | 1 | One-cycle pulse marking a new word |
| busy_o | output | 1 | Request in progress |

## Verification
The bench plays the converter on the pins. It puts the stored word's MSB on the line when the start line falls and shifts the word on each falling serial-clock edge. Once the word is exhausted it drives zeros. The words tried are all zeros, all ones, alternating patterns, a lone MSB, a lone LSB and mixed values. Together they expose a reversed bit order, a stuck bit, an off-by-one capture and a lost edge bit. The waits and divider settings are varied, including a wait of 0 and a divider of 0, so that an error in the wait count or the clock half-period shows up as a shifted edge time. Other runs toggle the request and change the settings in the middle of a transfer. They show whether requests made while busy are ignored and whether the settings are latched at acceptance.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    typedef enum logic [2:0] {
        ST_WAKE  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_CONV  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_DONE  = 3'd4
    } rd_state_t;

endpackage

// File: rtl/sar_rd_waitcnt.sv
module sar_rd_waitcnt #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              run_i,
    output logic              zero_o
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= wait_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sar_rd_sclkgen.sv
module sar_rd_sclkgen #(
    parameter int DIV_W = 8,
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic             run_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             last_o
);

    localparam int BCNT_W = $clog2(NBITS + 1);
    localparam logic [BCNT_W-1:0] BITS_ALL = BCNT_W'(NBITS);

    logic [DIV_W-1:0]  half_q;
    logic [DIV_W-1:0]  tick_q;
    logic [BCNT_W-1:0] bits_q;
    logic              sclk_q;
    logic [DIV_W-1:0]  half_eff;
    logic              toggle;

    assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
    assign toggle   = run_i && (tick_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= DIV_W'(1);
            tick_q <= '0;
            bits_q <= '0;
            sclk_q <= 1'b0;
        end else if (load_i) begin
            half_q <= half_eff;
            tick_q <= half_eff - 1'b1;
            bits_q <= '0;
            sclk_q <= 1'b0;
        end else if (run_i) begin
            if (tick_q == '0) begin
                tick_q <= half_q - 1'b1;
                sclk_q <= ~sclk_q;
                if (!sclk_q) begin
                    bits_q <= bits_q + 1'b1;
                end
            end else begin
                tick_q <= tick_q - 1'b1;
            end
        end
    end

    assign sclk_o = sclk_q;
    assign rise_o = toggle && !sclk_q;
    assign last_o = toggle && sclk_q && (bits_q == BITS_ALL);

endmodule

// File: rtl/sar_rd_shreg.sv
module sar_rd_shreg #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             sdi_i,
    input  logic             commit_i,
    output logic [NBITS-1:0] word_o
);

    logic [NBITS-1:0] sh_q;
    logic [NBITS-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            word_q <= '0;
        end else begin
            if (shift_i) begin
                sh_q <= {sh_q[NBITS-2:0], sdi_i};
            end
            if (commit_i) begin
                word_q <= sh_q;
            end
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/sar_rd_top.sv
module sar_rd_top
    import sar_rd_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DIV_W  = 8,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              sdi_i,
    output logic              conv_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              busy_o
);

    rd_state_t st_q, st_d;
    logic      accept;
    logic      wait_zero;
    logic      bit_rise;
    logic      word_last;

    assign accept = (st_q == ST_IDLE) && start_i;

    sar_rd_waitcnt #(.WAIT_W(WAIT_W)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .wait_i (wait_i),
        .run_i  (st_q == ST_CONV),
        .zero_o (wait_zero)
    );

    sar_rd_sclkgen #(.DIV_W(DIV_W), .NBITS(DATA_W)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .half_i (div_i),
        .run_i  (st_q == ST_SHIFT),
        .sclk_o (sclk_o),
        .rise_o (bit_rise),
        .last_o (word_last)
    );

    sar_rd_shreg #(.NBITS(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (bit_rise),
        .sdi_i    (sdi_i),
        .commit_i (word_last),
        .word_o   (data_o)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAKE:  st_d = ST_IDLE;
            ST_IDLE:  if (start_i)   st_d = ST_CONV;
            ST_CONV:  if (wait_zero) st_d = ST_SHIFT;
            ST_SHIFT: if (word_last) st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_WAKE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        conv_o  = 1'b1;
        busy_o  = 1'b0;
        valid_o = 1'b0;
        unique case (st_q)
            ST_WAKE:  conv_o = 1'b0;
            ST_IDLE:  ;
            ST_CONV:  busy_o = 1'b1;
            ST_SHIFT: begin
                conv_o = 1'b0;
                busy_o = 1'b1;
            end
            ST_DONE:  valid_o = 1'b1;
            default:  conv_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_rd_chk.sv
module sar_rd_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              conv_o,
    input logic              sclk_o,
    input logic              busy_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] data_o
);

    p_busy_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    p_conv_falls_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_o) |-> busy_o);

    p_idle_sclk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    p_sclk_conv_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !conv_o);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_busy_ends_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> valid_o);

    p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

    p_sleep_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> conv_o);

endmodule

bind sar_rd_top sar_rd_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .conv_o  (conv_o),
    .sclk_o  (sclk_o),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .data_o  (data_o)
);

// File: tb/sar_rd_top_tb_top.sv
`timescale 1ns/1ps
module sar_rd_top_tb_top;

    localparam int DATA_W = 12;
    localparam int DIV_W  = 8;
    localparam int WAIT_W = 16;

    typedef struct packed {
        logic [WAIT_W-1:0] w;
        logic [DIV_W-1:0]  d;
        logic [DATA_W-1:0] v;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{w: 16'd0,  d: 8'd1, v: 12'h000},
        '{w: 16'd3,  d: 8'd2, v: 12'hFFF},
        '{w: 16'd10, d: 8'd3, v: 12'hA5A},
        '{w: 16'd1,  d: 8'd1, v: 12'h800},
        '{w: 16'd5,  d: 8'd4, v: 12'h001},
        '{w: 16'd2,  d: 8'd0, v: 12'h5A5},
        '{w: 16'd7,  d: 8'd5, v: 12'h7FE},
        '{w: 16'd0,  d: 8'd2, v: 12'h123}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [DIV_W-1:0]  div_i = '0;
    logic [WAIT_W-1:0] wait_i = '0;
    logic              sdi_i = 1'b0;
    logic              conv_o, sclk_o, valid_o, busy_o;
    logic [DATA_W-1:0] data_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] dev_word = '0;
    int                dev_idx  = -1;

    always #2 clk = ~clk;

    sar_rd_top #(.DATA_W(DATA_W), .DIV_W(DIV_W), .WAIT_W(WAIT_W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .div_i   (div_i),
        .wait_i  (wait_i),
        .sdi_i   (sdi_i),
        .conv_o  (conv_o),
        .sclk_o  (sclk_o),
        .data_o  (data_o),
        .valid_o (valid_o),
        .busy_o  (busy_o)
    );

    // Converter model: MSB on start-line fall, next bit on each sclk fall, then zeros
    always @(negedge conv_o) begin
        dev_idx = DATA_W - 1;
        sdi_i   = dev_word[DATA_W-1];
    end

    always @(negedge sclk_o) begin
        if (dev_idx > 0) begin
            dev_idx = dev_idx - 1;
            sdi_i   = dev_word[dev_idx];
        end else begin
            dev_idx = -1;
            sdi_i   = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic run_xfer(input int w, input int d, input logic [DATA_W-1:0] word, input bit poke);
        int h, cnt, rises, first_rise;
        logic prev;
        h = (d == 0) ? 1 : d;
        dev_word = word;
        @(negedge clk);
        while (busy_o || valid_o) @(negedge clk);
        wait_i  = WAIT_W'(w);
        div_i   = DIV_W'(d);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && conv_o, "R2 busy up with conv high", {busy_o, conv_o}, 3);
        if (poke) begin
            wait_i = WAIT_W'(w + 9);
            div_i  = DIV_W'(d + 3);
        end
        cnt = 0;
        while (conv_o && cnt < 5000) begin
            if (poke) start_i = ~start_i;
            @(negedge clk);
            cnt++;
        end
        chk(cnt == w + 1, poke ? "R8 wait latched" : "R2 conv high time", cnt, w + 1);
        chk(!sclk_o, "R3 sclk low at readout start", sclk_o, 0);
        cnt = 0; rises = 0; first_rise = -1; prev = sclk_o;
        while (!valid_o && cnt < 100000) begin
            if (poke) start_i = ~start_i;
            @(negedge clk);
            cnt++;
            if (sclk_o && !prev) begin
                rises++;
                if (first_rise < 0) first_rise = cnt;
            end
            prev = sclk_o;
        end
        start_i = 1'b0;
        chk(first_rise == h, poke ? "R8 div latched" : "R3 first rise delay", first_rise, h);
        chk(rises == 12, "R5 twelve rising edges", rises, 12);
        chk(cnt == 24 * h, "R6 valid timing", cnt, 24 * h);
        chk(data_o == word, "R4 word assembled MSB first", int'(data_o), int'(word));
        chk(!busy_o && conv_o && !sclk_o, "R9 conv high busy low at valid",
            {busy_o, conv_o, sclk_o}, 2);
        @(negedge clk);
        chk(!valid_o, "R6 valid one cycle", valid_o, 0);
        chk(data_o == word, "R6 word held", int'(data_o), int'(word));
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(!busy_o && conv_o, "R7 no extra transfer from busy requests", busy_o, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(!conv_o && !sclk_o && !busy_o && !valid_o && data_o == '0, "R1 reset outputs",
            {conv_o, sclk_o, busy_o, valid_o}, 0);
        rst_n = 1'b1;
        #1;
        chk(!conv_o, "R1 conv low first cycle", conv_o, 0);
        @(negedge clk);
        chk(conv_o && !busy_o, "R1 conv high after wake", conv_o, 1);
        repeat (2) @(negedge clk);
        chk(conv_o && !sclk_o, "R9 sleep while idle", conv_o, 1);

        foreach (VECS[i]) begin
            run_xfer(int'(VECS[i].w), int'(VECS[i].d), VECS[i].v, 1'b0);
        end

        // Requests and setting changes during a transfer
        run_xfer(4, 2, 12'h9C3, 1'b1);
        run_xfer(0, 1, 12'h3C6, 1'b1);

        // Zero divider means half-period of one cycle
        run_xfer(1, 0, 12'hB71, 1'b0);

        // Reset in the middle of readout
        dev_word = 12'hFFF;
        @(negedge clk);
        wait_i = '0; div_i = 8'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(!conv_o && !sclk_o && !busy_o && !valid_o && data_o == '0, "R1 reset mid readout",
            {conv_o, sclk_o, busy_o, valid_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_o && !busy_o, "R1 recovery to sleep", conv_o, 1);

        run_xfer(2, 2, 12'h6E9, 1'b0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule